// File: doc/BRIEF.md
# Bit-Reversed Vector Load Address Unit

This block sequences a vectorised integer load across a group of elements and forms each element's effective address. After a start pulse it walks an element counter from 0 to VL-1 and issues one memory read request per element. The offset for an element is built in three steps:

- reverse the low log2(VL) bits of the element counter;
- multiply that value by a sign-extended 16-bit displacement;
- shift the product left by a six-bit amount taken from the low bits of a third register.

The offset is then added to a base value.

Each returned datum is zero- or sign-extended into a 64-bit result according to the load kind. For update forms the unit also presents the element's effective address as a write-back value for the base register.

The caller latches all operands with the start pulse. It presents memory through two valid/ready channels, a request channel and a tagged response channel, and consumes one result pulse per element. The unit keeps a single request in flight. It raises a completion pulse together with the last result.

Top module: `bitrev_ld_agu`

## Requirements
- R1: Operands are latched on a start pulse accepted while idle. In non-update forms the base is zero when `ra_is_zero` is 1, and `ra_val` otherwise. In update forms (`upd`=1) the base is always `ra_val`.
- R2: The element address is base + ((rev × sext(disp)) << `sh_amt`), computed modulo 2^64. Only the low 64 bits of the product are kept, and bits shifted past bit 63 are discarded. `rev` is the element index with its low `vl_log2` bits reversed and its other bits zero.
- R3: For kinds 4 and 5, bits [1:0] of `disp` are forced to zero before sign extension. All other kinds use all 16 bits.
- R4: Kind codes: 0 = byte, 1 = halfword and 3 = word zero-extend the low 8, 16 or 32 bits of `rsp_data` into the result. All upper bits of the result are zero.
- R5: Kinds 2 (halfword) and 4 (word) sign-extend the low 16 or 32 bits of `rsp_data`. Kinds 5, 6 and 7 pass all 64 bits unchanged.
- R6: VL = 2^min(`vl_log2`,6). Requests carry `req_elem` = 0, 1, …, VL-1 in order. With VL=1 the offset is always zero.
- R7: `req_size` gives the byte count as one-hot: 1 for kind 0, 2 for kinds 1–2, 4 for kinds 3–4 and 8 otherwise. A request held while `req_ready` is low keeps its address and element unchanged.
- R8: `rsp_ready` is high only while a request is awaiting its response. The cycle after a response handshake, `res_valid` pulses with the extended data and with `res_elem` equal to `rsp_elem`.
- R9: In update forms, `wb_valid` pulses together with each `res_valid`, and `wb_data` carries that element's address. In non-update forms `wb_valid` stays low.
- R10: `done` pulses together with the last element's result, after which `busy` is low. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a vector load (accepted when idle) |
| kind | input | 3 | Load kind code |
| upd | input | 1 | Update form: base is RA, address written back |
| ra_is_zero | input | 1 | RA field is 0 |
| ra_val | input | 64 | Contents of RA |
| sh_amt | input | 6 | Low six bits of the shift register |
| disp | input | 16 | Displacement field |
| vl_log2 | input | 3 | log2 of vector length |
| busy | output | 1 | Sequence in progress |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_addr | output | 64 | Request address |
| req_size | output | 4 | One-hot byte count |
| req_elem | output | 6 | Element index of the request |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Unit can accept a response |
| rsp_data | input | 64 | Response data, low-aligned |
| rsp_elem | input | 6 | Element tag of the response |
| res_valid | output | 1 | Result pulse |
| res_data | output | 64 | Extended result |
| res_elem | output | 6 | Element index of the result |
| wb_valid | output | 1 | Base write-back pulse |
| wb_data | output | 64 | Address to write back |
| done | output | 1 | Last result delivered |

## Verification
The embedded assertions check the following on every cycle:
- the request address and element stay stable while a request is stalled;
- the size code is one-hot;
- results only follow a response handshake;
- write-back and completion pulses only coincide with a result;
- byte loads carry no upper bits.

The arithmetic itself can only be shown by the bench's scenarios. That covers bit reversal for every vector length, the sign of the displacement, the DS-form masking, overflow of the multiply and of the shift, and the base selection. The same applies to the order of elements, the extension per kind and the ignoring of a start issued mid-run. For these, the bench compares each request and result with values it computes itself.

// File: rtl/bitrev_ld_pkg.sv
package bitrev_ld_pkg;

  typedef enum logic [2:0] {
    LK_BZ = 3'd0,
    LK_HZ = 3'd1,
    LK_HA = 3'd2,
    LK_WZ = 3'd3,
    LK_WA = 3'd4,
    LK_DW = 3'd5,
    LK_X6 = 3'd6,
    LK_X7 = 3'd7
  } ld_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } seq_st_e;

  // displacement low bits are cleared for the two DS-style kinds
  function automatic logic kind_is_ds(ld_kind_e k);
    return (k == LK_WA) || (k == LK_DW);
  endfunction

  function automatic logic [3:0] kind_bytes(ld_kind_e k);
    case (k)
      LK_BZ:        return 4'b0001;
      LK_HZ, LK_HA: return 4'b0010;
      LK_WZ, LK_WA: return 4'b0100;
      default:      return 4'b1000;
    endcase
  endfunction

endpackage

// File: rtl/br_index.sv
module br_index #(
  parameter int IDX_W = 6,
  parameter int LW    = $clog2(IDX_W + 1)
) (
  input  logic [IDX_W-1:0] step,
  input  logic [LW-1:0]    vlog,
  output logic [IDX_W-1:0] rev
);

  logic [IDX_W-1:0] cand [IDX_W+1];

  // one reversal network per possible vector length
  for (genvar k = 0; k <= IDX_W; k++) begin : g_len
    logic [IDX_W-1:0] r;
    always_comb begin
      r = '0;
      for (int j = 0; j < k; j++) r[j] = step[k-1-j];
    end
    assign cand[k] = r;
  end

  always_comb begin
    rev = '0;
    for (int k = 0; k <= IDX_W; k++) begin
      if (vlog == LW'(k)) rev = cand[k];
    end
  end

endmodule

// File: rtl/br_addr.sv
module br_addr #(
  parameter int XLEN   = 64,
  parameter int IDX_W  = 6,
  parameter int DISP_W = 16,
  parameter int SHW    = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]   base,
  input  logic [IDX_W-1:0]  rev,
  input  logic [DISP_W-1:0] disp,
  input  logic              ds,
  input  logic [SHW-1:0]    shamt,
  output logic [XLEN-1:0]   ea
);

  logic [DISP_W-1:0] d_m;
  logic [XLEN-1:0]   d_x;
  logic [XLEN-1:0]   rev_x;
  logic [XLEN-1:0]   prod;
  logic [XLEN-1:0]   off;

  always_comb begin
    d_m   = ds ? {disp[DISP_W-1:2], 2'b00} : disp;
    d_x   = {{(XLEN-DISP_W){d_m[DISP_W-1]}}, d_m};
    rev_x = {{(XLEN-IDX_W){1'b0}}, rev};
    prod  = rev_x * d_x;
    off   = prod << shamt;
    ea    = base + off;
  end

endmodule

// File: rtl/br_ext.sv
module br_ext
  import bitrev_ld_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  ld_kind_e        kind,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] res
);

  always_comb begin
    case (kind)
      LK_BZ:   res = {{(XLEN-8){1'b0}}, raw[7:0]};
      LK_HZ:   res = {{(XLEN-16){1'b0}}, raw[15:0]};
      LK_HA:   res = {{(XLEN-16){raw[15]}}, raw[15:0]};
      LK_WZ:   res = {{(XLEN-32){1'b0}}, raw[31:0]};
      LK_WA:   res = {{(XLEN-32){raw[31]}}, raw[31:0]};
      default: res = raw;
    endcase
  end

endmodule

// File: rtl/bitrev_ld_agu.sv
module bitrev_ld_agu
  import bitrev_ld_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IDX_W  = 6,
  parameter int DISP_W = 16,
  parameter int LW     = $clog2(IDX_W + 1),
  parameter int SHW    = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        kind,
  input  logic              upd,
  input  logic              ra_is_zero,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [SHW-1:0]    sh_amt,
  input  logic [DISP_W-1:0] disp,
  input  logic [LW-1:0]     vl_log2,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [XLEN-1:0]   req_addr,
  output logic [3:0]        req_size,
  output logic [IDX_W-1:0]  req_elem,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [XLEN-1:0]   rsp_data,
  input  logic [IDX_W-1:0]  rsp_elem,
  output logic              res_valid,
  output logic [XLEN-1:0]   res_data,
  output logic [IDX_W-1:0]  res_elem,
  output logic              wb_valid,
  output logic [XLEN-1:0]   wb_data,
  output logic              done
);

  seq_st_e           st_q, st_d;
  ld_kind_e          kind_q;
  logic              upd_q;
  logic [XLEN-1:0]   base_q;
  logic [SHW-1:0]    sh_q;
  logic [DISP_W-1:0] disp_q;
  logic [LW-1:0]     vlog_q;
  logic [IDX_W-1:0]  step_q, step_d;
  logic [XLEN-1:0]   ea_q;
  logic              res_valid_q, wb_valid_q, done_q;
  logic [XLEN-1:0]   res_data_q;
  logic [IDX_W-1:0]  res_elem_q;

  logic              op_en, ea_en, rsp_fire, last_d;
  logic [LW-1:0]     vlog_in;
  logic [IDX_W-1:0]  last_idx;
  logic [IDX_W-1:0]  rev;
  logic [XLEN-1:0]   ea;
  logic [XLEN-1:0]   ext;

  br_index #(.IDX_W(IDX_W), .LW(LW)) u_rev (
    .step (step_q),
    .vlog (vlog_q),
    .rev  (rev)
  );

  br_addr #(.XLEN(XLEN), .IDX_W(IDX_W), .DISP_W(DISP_W), .SHW(SHW)) u_addr (
    .base  (base_q),
    .rev   (rev),
    .disp  (disp_q),
    .ds    (kind_is_ds(kind_q)),
    .shamt (sh_q),
    .ea    (ea)
  );

  br_ext #(.XLEN(XLEN)) u_ext (
    .kind (kind_q),
    .raw  (rsp_data),
    .res  (ext)
  );

  always_comb begin
    vlog_in = (int'(vl_log2) > IDX_W) ? LW'(IDX_W) : vl_log2;
    for (int i = 0; i < IDX_W; i++) last_idx[i] = (i < int'(vlog_q));
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    op_en    = 1'b0;
    ea_en    = 1'b0;
    rsp_fire = 1'b0;
    last_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          op_en  = 1'b1;
          step_d = '0;
          st_d   = ST_REQ;
        end
      end
      ST_REQ: begin
        if (req_ready) begin
          ea_en = 1'b1;
          st_d  = ST_RSP;
        end
      end
      ST_RSP: begin
        if (rsp_valid) begin
          rsp_fire = 1'b1;
          if (step_q == last_idx) begin
            last_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            step_d = step_q + 1'b1;
            st_d   = ST_REQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      step_q      <= '0;
      kind_q      <= LK_BZ;
      upd_q       <= 1'b0;
      base_q      <= '0;
      sh_q        <= '0;
      disp_q      <= '0;
      vlog_q      <= '0;
      ea_q        <= '0;
      res_valid_q <= 1'b0;
      wb_valid_q  <= 1'b0;
      done_q      <= 1'b0;
      res_data_q  <= '0;
      res_elem_q  <= '0;
    end else begin
      st_q        <= st_d;
      step_q      <= step_d;
      res_valid_q <= rsp_fire;
      wb_valid_q  <= rsp_fire & upd_q;
      done_q      <= last_d;
      if (op_en) begin
        kind_q <= ld_kind_e'(kind);
        upd_q  <= upd;
        base_q <= (upd || !ra_is_zero) ? ra_val : '0;
        sh_q   <= sh_amt;
        disp_q <= disp;
        vlog_q <= vlog_in;
      end
      if (ea_en) ea_q <= ea;
      if (rsp_fire) begin
        res_data_q <= ext;
        res_elem_q <= rsp_elem;
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign req_valid = (st_q == ST_REQ);
  assign rsp_ready = (st_q == ST_RSP);
  assign req_addr  = ea;
  assign req_size  = kind_bytes(kind_q);
  assign req_elem  = step_q;
  assign res_valid = res_valid_q;
  assign res_data  = res_data_q;
  assign res_elem  = res_elem_q;
  assign wb_valid  = wb_valid_q;
  assign wb_data   = ea_q;
  assign done      = done_q;

  // R7: a stalled request keeps address and element
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_elem)));

  // R7: size code is one-hot
  a_r7_size_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(req_size) == 1));

  // R8: a result follows a response handshake
  a_r8_res_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(rsp_valid && rsp_ready));

  // R9: write-back only beside a result
  a_r9_wb_with_res: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> res_valid);

  // R10: completion beside the last result, then idle
  a_r10_done_with_res: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_valid && !busy));

  // R4: byte loads carry no upper bits
  a_r4_byte_zero_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && kind_q == LK_BZ) |-> (res_data[XLEN-1:8] == '0));

endmodule

// File: tb/bitrev_ld_agu_tb.sv
`timescale 1ns/1ps
module bitrev_ld_agu_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  kind;
  logic        upd, ra_is_zero;
  logic [63:0] ra_val;
  logic [5:0]  sh_amt;
  logic [15:0] disp;
  logic [2:0]  vl_log2;
  logic        busy, req_valid, req_ready;
  logic [63:0] req_addr;
  logic [3:0]  req_size;
  logic [5:0]  req_elem;
  logic        rsp_valid, rsp_ready;
  logic [63:0] rsp_data;
  logic [5:0]  rsp_elem;
  logic        res_valid, wb_valid, done;
  logic [63:0] res_data, wb_data;
  logic [5:0]  res_elem;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bitrev_ld_agu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .upd(upd),
    .ra_is_zero(ra_is_zero), .ra_val(ra_val), .sh_amt(sh_amt), .disp(disp),
    .vl_log2(vl_log2), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_elem(req_elem),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_elem(rsp_elem), .res_valid(res_valid), .res_data(res_data),
    .res_elem(res_elem), .wb_valid(wb_valid), .wb_data(wb_data), .done(done)
  );

  function automatic int bitrev_f(int s, int lg);
    int r = 0;
    for (int j = 0; j < lg; j++) if (s[lg-1-j]) r |= (1 << j);
    return r;
  endfunction

  function automatic logic [63:0] exp_ea(int k, bit u, bit rz, logic [63:0] ra,
                                         int sh, logic [15:0] d, int s, int lg);
    logic [15:0] dd;
    logic [63:0] b, sx, r;
    dd = d;
    if (k == 4 || k == 5) dd[1:0] = 2'b00;
    b  = (u || !rz) ? ra : 64'd0;
    sx = {{48{dd[15]}}, dd};
    r  = 64'(bitrev_f(s, lg));
    return b + ((r * sx) << sh);
  endfunction

  function automatic logic [63:0] exp_ext(int k, logic [63:0] d);
    case (k)
      0: return {56'd0, d[7:0]};
      1: return {48'd0, d[15:0]};
      2: return {{48{d[15]}}, d[15:0]};
      3: return {32'd0, d[31:0]};
      4: return {{32{d[31]}}, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [3:0] exp_size(int k);
    case (k)
      0: return 4'b0001;
      1, 2: return 4'b0010;
      3, 4: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one vector load; inj drives a conflicting start while busy
  task automatic run_op(int k, bit u, bit rz, logic [63:0] ra, int sh,
                        logic [15:0] d, int lg_in, bit inj);
    int lg, vl, nreq, nres, cyc;
    bit have_pend, inflight, fin;
    int pend_elem, fly_elem;
    logic [63:0] fly_data;
    logic [63:0] addr_of [64];
    lg = (lg_in > 6) ? 6 : lg_in;
    vl = 1 << lg;
    nreq = 0; nres = 0; have_pend = 0; inflight = 0; fin = 0; cyc = 0;
    pend_elem = 0; fly_elem = 0; fly_data = '0;
    @(negedge clk);
    start = 1'b1; kind = 3'(k); upd = u; ra_is_zero = rz; ra_val = ra;
    sh_amt = 6'(sh); disp = d; vl_log2 = 3'(lg_in);
    @(negedge clk);
    // R1: operands are latched; scramble them after the start
    ra_val = {$urandom, $urandom}; disp = 16'($urandom); sh_amt = 6'($urandom);
    kind = 3'($urandom); upd = ~u; ra_is_zero = ~rz; vl_log2 = 3'($urandom);
    start = inj;  // R10: ignored while busy
    while (!fin && cyc < 2000) begin
      if (cyc > 0) @(negedge clk);
      start = 1'b0;
      cyc++;
      if (res_valid) begin
        chk(inflight, "R8 result without response", 64'(res_valid), 64'(inflight));
        chk(res_elem == 6'(fly_elem), "R8 res_elem", 64'(res_elem), 64'(fly_elem));
        chk(res_data == exp_ext(k, fly_data), (k == 2 || k >= 4) ? "R5 ext" : "R4 ext",
            res_data, exp_ext(k, fly_data));
        if (u) begin
          chk(wb_valid && wb_data == addr_of[fly_elem], "R9 wb",
              wb_data, addr_of[fly_elem]);
        end else begin
          chk(!wb_valid, "R9 no wb", 64'(wb_valid), 64'd0);
        end
        nres++;
        inflight = 0;
        rsp_valid = 1'b0;
        chk(done == (nres == vl), "R10 done", 64'(done), 64'(nres == vl));
        if (done) begin
          fin = 1;
          chk(!busy, "R10 busy low", 64'(busy), 64'd0);
          chk(nres == vl && nreq == vl, "R6 count", 64'(nres), 64'(vl));
        end
      end else begin
        chk(!done, "R10 spurious done", 64'(done), 64'd0);
      end
      if (!fin) begin
        if (req_valid && !have_pend && !inflight && ($urandom % 3 != 0)) begin
          addr_of[nreq] = exp_ea(k, u, rz, ra, sh, d, nreq, lg);
          chk(req_elem == 6'(nreq), "R6 elem order", 64'(req_elem), 64'(nreq));
          chk(req_addr == addr_of[nreq], (k >= 4) ? "R3 addr" : "R2 addr",
              req_addr, addr_of[nreq]);
          chk(req_size == exp_size(k), "R7 size", 64'(req_size), 64'(exp_size(k)));
          req_ready = 1'b1;
          have_pend = 1;
          pend_elem = nreq;
          nreq++;
        end else begin
          req_ready = 1'b0;
        end
        if (have_pend && !inflight && !req_ready && ($urandom % 2 == 0)) begin
          chk(rsp_ready, "R8 rsp_ready", 64'(rsp_ready), 64'd1);
          fly_data  = {$urandom, $urandom};
          fly_elem  = pend_elem;
          rsp_valid = 1'b1;
          rsp_data  = fly_data;
          rsp_elem  = 6'(pend_elem);
          inflight  = 1;
          have_pend = 0;
        end
      end
    end
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    chk(fin, "R10 completion", 64'(fin), 64'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; kind = '0; upd = 1'b0; ra_is_zero = 1'b0;
    ra_val = '0; sh_amt = '0; disp = '0; vl_log2 = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; rsp_elem = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid && !res_valid && !wb_valid && !done, "R10 reset state",
        {busy, req_valid, res_valid, wb_valid, done}, 64'd0);
    chk(!rsp_ready, "R8 reset rsp_ready", 64'(rsp_ready), 64'd0);

    // directed corner cases
    run_op(0, 0, 1, 64'h1234_5678_9abc_def0, 3, 16'h0010, 0, 0);   // R1 zero base, R6 VL=1
    run_op(1, 0, 0, 64'h0000_0000_0000_1000, 0, 16'hfffe, 3, 0);   // R2 negative disp
    run_op(2, 1, 1, 64'h8000_0000_0000_0000, 4, 16'h0101, 2, 1);   // R1 update, R10 inject
    run_op(4, 0, 0, 64'h0000_0000_0000_0400, 2, 16'h7fff, 4, 0);   // R3 DS masking
    run_op(5, 1, 0, 64'hffff_ffff_ffff_fff0, 63, 16'h0003, 6, 0);  // R2 shift overflow
    run_op(3, 0, 0, 64'h0, 60, 16'h8000, 5, 1);                    // R2 product overflow
    run_op(6, 0, 0, 64'h10, 1, 16'h0008, 7, 0);                    // R5 code 6, R6 clamp

    for (int i = 0; i < 40; i++) begin
      run_op(int'($urandom % 8), bit'($urandom), bit'($urandom), {$urandom, $urandom},
             int'($urandom % 64), 16'($urandom), int'($urandom % 7), bit'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule